// File: doc/BRIEF.md
# Partitioned 128-bit SIMD ALU

This block is an integer execution unit for packed data. Each cycle it takes two 128-bit source operands, a 5-bit operation code and a 5-bit destination register index. One clock edge later it presents a 128-bit result and a write enable for the register file. The opcode picks both the operation and the lane size. The same datapath then acts as sixteen 8-bit lanes, eight 16-bit lanes or four 32-bit lanes. Carries, borrows and clamps never leak from one lane into the next.

Per lane the unit can do wrapping add and subtract, saturating add and subtract in signed or unsigned form, a signed greater-than compare and an equality compare. A compare fills its lane with a mask of all ones or all zeros. Four bitwise logic operations ignore lane boundaries and act on all 128 bits. Index 0 is the hard-wired zero register, so an operation that targets it produces no write.

Top module: `simd_alu`

## Requirements
- R1: The opcode on `op_i` selects operation and lane width. Codes 0..23 form eight groups of three: add, sub, signed-saturating add, signed-saturating sub, unsigned-saturating add, unsigned-saturating sub, greater-than compare, equal compare. Within a group, code offset 0, 1 and 2 select 8-, 16- and 32-bit lanes. Codes 24, 25, 26 and 27 are AND, OR, XOR and NOR.
- R2: Wrapping add and subtract work modulo 2^W in every lane of width W. A carry or borrow never reaches the neighbouring lane.
- R3: On overflow, a signed saturating add or subtract clamps the lane to its most positive value (0x7F.., if the true result is too large) or its most negative value (0x80.., if too small).
- R4: An unsigned saturating add clamps the lane to all ones on carry out. An unsigned saturating subtract clamps the lane to zero when the subtrahend is larger.
- R5: The greater-than compare writes all ones into a lane when the `src_a_i` lane, read as a signed number, is strictly greater than the `src_b_i` lane, and all zeros otherwise.
- R6: The equal compare writes all ones into a lane when the two lanes are equal, and all zeros otherwise.
- R7: AND, OR, XOR and NOR act bitwise on all 128 bits, whatever lane size came before.
- R8: For a supported opcode, `we_o` is high exactly when `dst_i` is nonzero. With `dst_i` equal to 0, `we_o` stays low.
- R9: Codes 28 to 31 are unsupported. They give a zero `res_o` and a low `we_o`.
- R10: Outputs are registered, so results appear one clock after the inputs. While `rst_ni` is low, `res_o` is zero and `we_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| dst_i | input | 5 | Destination register index |
| src_a_i | input | 128 | First source operand |
| src_b_i | input | 128 | Second source operand |
| res_o | output | 128 | Result, registered |
| we_o | output | 1 | Write enable for the destination, registered |

## Verification
Uniform random operands almost never hit the clamp edges or lane-exact ties. Examples are a signed byte at 0x7F plus a positive value, an unsigned subtract whose borrow lands in the top lane only, or a greater-than on equal lanes. The stimulus therefore builds operands lane by lane from a small pool of extremes (0, 1, the signed limits, all ones) mixed with random lanes. It also adds directed vectors where every lane carries out at once, to catch a carry crossing into its neighbour.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam int unsigned OP_W     = 5;
  localparam int unsigned N_WIDTHS = 3;  // 8, 16, 32 bit lanes

  typedef enum logic [OP_W-1:0] {
    OP_ADD_B = 5'd0,  OP_ADD_H = 5'd1,  OP_ADD_W = 5'd2,
    OP_SUB_B = 5'd3,  OP_SUB_H = 5'd4,  OP_SUB_W = 5'd5,
    OP_ADS_B = 5'd6,  OP_ADS_H = 5'd7,  OP_ADS_W = 5'd8,
    OP_SBS_B = 5'd9,  OP_SBS_H = 5'd10, OP_SBS_W = 5'd11,
    OP_ADU_B = 5'd12, OP_ADU_H = 5'd13, OP_ADU_W = 5'd14,
    OP_SBU_B = 5'd15, OP_SBU_H = 5'd16, OP_SBU_W = 5'd17,
    OP_CGT_B = 5'd18, OP_CGT_H = 5'd19, OP_CGT_W = 5'd20,
    OP_CEQ_B = 5'd21, OP_CEQ_H = 5'd22, OP_CEQ_W = 5'd23,
    OP_AND   = 5'd24, OP_OR    = 5'd25, OP_XOR   = 5'd26,
    OP_NOR   = 5'd27
  } simd_op_e;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_ADDS, K_SUBS, K_ADDU, K_SUBU,
    K_CGT, K_CEQ, K_AND, K_OR, K_XOR, K_NOR, K_NONE
  } kind_e;

  typedef enum logic [1:0] {LW_8 = 2'd0, LW_16 = 2'd1, LW_32 = 2'd2} lane_w_e;

  typedef struct packed {
    kind_e   kind;
    lane_w_e lw;
    logic    ok;
  } ctrl_t;
endpackage

// File: rtl/simd_decode.sv
module simd_decode
  import simd_alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o
);
  logic [OP_W-1:0] grp;
  logic [1:0]      sub;

  always_comb begin
    grp         = op_i / OP_W'(3);
    sub         = 2'(op_i % OP_W'(3));
    ctrl_o.kind = K_NONE;
    ctrl_o.lw   = LW_8;
    ctrl_o.ok   = 1'b0;
    if (op_i < OP_W'(24)) begin
      ctrl_o.ok = 1'b1;
      unique case (sub)
        2'd0:    ctrl_o.lw = LW_8;
        2'd1:    ctrl_o.lw = LW_16;
        default: ctrl_o.lw = LW_32;
      endcase
      unique case (grp)
        OP_W'(0): ctrl_o.kind = K_ADD;
        OP_W'(1): ctrl_o.kind = K_SUB;
        OP_W'(2): ctrl_o.kind = K_ADDS;
        OP_W'(3): ctrl_o.kind = K_SUBS;
        OP_W'(4): ctrl_o.kind = K_ADDU;
        OP_W'(5): ctrl_o.kind = K_SUBU;
        OP_W'(6): ctrl_o.kind = K_CGT;
        default:  ctrl_o.kind = K_CEQ;
      endcase
    end else begin
      unique case (op_i)
        OP_AND: begin ctrl_o.kind = K_AND; ctrl_o.ok = 1'b1; end
        OP_OR:  begin ctrl_o.kind = K_OR;  ctrl_o.ok = 1'b1; end
        OP_XOR: begin ctrl_o.kind = K_XOR; ctrl_o.ok = 1'b1; end
        OP_NOR: begin ctrl_o.kind = K_NOR; ctrl_o.ok = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/simd_lane.sv
module simd_lane
  import simd_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  kind_e        kind_i,
  output logic [W-1:0] y_o
);
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] sum, dif;
  logic       ovf_add, ovf_sub, gt, eq;

  always_comb begin
    sum     = {1'b0, a_i} + {1'b0, b_i};
    dif     = {1'b0, a_i} - {1'b0, b_i};
    // signed overflow: result sign departs from a's sign under these operand signs
    ovf_add = (a_i[W-1] == b_i[W-1]) && (sum[W-1] != a_i[W-1]);
    ovf_sub = (a_i[W-1] != b_i[W-1]) && (dif[W-1] != a_i[W-1]);
    gt      = $signed(a_i) > $signed(b_i);
    eq      = a_i == b_i;
    unique case (kind_i)
      K_ADD:   y_o = sum[W-1:0];
      K_SUB:   y_o = dif[W-1:0];
      K_ADDS:  y_o = ovf_add ? (a_i[W-1] ? S_MIN : S_MAX) : sum[W-1:0];
      K_SUBS:  y_o = ovf_sub ? (a_i[W-1] ? S_MIN : S_MAX) : dif[W-1:0];
      K_ADDU:  y_o = sum[W] ? '1 : sum[W-1:0];
      K_SUBU:  y_o = dif[W] ? '0 : dif[W-1:0];
      K_CGT:   y_o = gt ? '1 : '0;
      K_CEQ:   y_o = eq ? '1 : '0;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  kind_e             kind_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int unsigned N_LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    simd_lane #(.W(LANE_W)) u_lane (
      .a_i   (a_i[l*LANE_W +: LANE_W]),
      .b_i   (b_i[l*LANE_W +: LANE_W]),
      .kind_i(kind_i),
      .y_o   (y_o[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [IDX_W-1:0]  dst_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              we_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] lane_y [N_WIDTHS];
  logic [DATA_W-1:0] res_d;
  logic              we_d;

  simd_decode u_dec (.op_i(op_i), .ctrl_o(ctrl));

  for (genvar g = 0; g < N_WIDTHS; g++) begin : g_bank
    simd_lane_bank #(.DATA_W(DATA_W), .LANE_W(8 << g)) u_bank (
      .a_i   (src_a_i),
      .b_i   (src_b_i),
      .kind_i(ctrl.kind),
      .y_o   (lane_y[g])
    );
  end

  always_comb begin
    res_d = '0;
    we_d  = 1'b0;
    if (ctrl.ok) begin
      we_d = dst_i != '0;
      unique case (ctrl.kind)
        K_AND: res_d = src_a_i & src_b_i;
        K_OR:  res_d = src_a_i | src_b_i;
        K_XOR: res_d = src_a_i ^ src_b_i;
        K_NOR: res_d = ~(src_a_i | src_b_i);
        default: begin
          unique case (ctrl.lw)
            LW_8:    res_d = lane_y[0];
            LW_16:   res_d = lane_y[1];
            default: res_d = lane_y[2];
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      we_o  <= 1'b0;
    end else begin
      res_o <= res_d;
      we_o  <= we_d;
    end
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned IDX_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [4:0]        op_i,
  input logic [IDX_W-1:0]  dst_i,
  input logic [DATA_W-1:0] src_a_i,
  input logic [DATA_W-1:0] src_b_i,
  input logic [DATA_W-1:0] res_o,
  input logic              we_o
);
  a_r8_dst_zero_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_i == '0) |=> !we_o);

  a_r8_valid_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i < 5'd28 && dst_i != '0) |=> we_o);

  a_r9_bad_op_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 5'd28) |=> (res_o == '0 && !we_o));

  a_r7_and_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd24) |=> (res_o == ($past(src_a_i) & $past(src_b_i))));

  a_r2_byte_lane1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd0) |=> (res_o[15:8] == 8'($past(src_a_i[15:8]) + $past(src_b_i[15:8]))));

  a_r4_addub_not_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd12) |=> (res_o[7:0] >= $past(src_a_i[7:0])));

  for (genvar l = 0; l < DATA_W / 32; l++) begin : g_mask
    a_r6_ceqw_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 5'd23) |=> (res_o[l*32 +: 32] == '0 || res_o[l*32 +: 32] == '1));
  end
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .op_i   (op_i),
  .dst_i  (dst_i),
  .src_a_i(src_a_i),
  .src_b_i(src_b_i),
  .res_o  (res_o),
  .we_o   (we_o)
);

// File: tb/simd_alu_bench.sv
module simd_alu_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [4:0]   op_i = 5'd28;
  logic [4:0]   dst_i = '0;
  logic [127:0] src_a_i = '0;
  logic [127:0] src_b_i = '0;
  logic [127:0] res_o;
  logic         we_o;
  int           total = 0;
  int           bad = 0;
  bit           done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  simd_alu u_simd_alu (.*);

  function automatic string tag_of(int op);
    if (op >= 28) return "R9";
    if (op >= 24) return "R7";
    case (op / 3)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4, 5:    return "R4";
      6:       return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [127:0] ref_res(int op, logic [127:0] a, logic [127:0] b);
    logic [127:0] r = '0;
    int w, grp;
    longint mask, x, y, sx, sy, v, smax, smin;
    if (op >= 28) return '0;
    if (op == 24) return a & b;
    if (op == 25) return a | b;
    if (op == 26) return a ^ b;
    if (op == 27) return ~(a | b);
    grp  = op / 3;
    w    = 8 << (op % 3);
    mask = (longint'(1) << w) - 1;
    smax = (longint'(1) << (w - 1)) - 1;
    smin = -(longint'(1) << (w - 1));
    for (int i = 0; i < 128 / w; i++) begin
      x  = longint'(a >> (i * w)) & mask;
      y  = longint'(b >> (i * w)) & mask;
      sx = (x > smax) ? x - (mask + 1) : x;
      sy = (y > smax) ? y - (mask + 1) : y;
      case (grp)
        0: v = x + y;
        1: v = x - y;
        2: begin v = sx + sy; if (v > smax) v = smax; if (v < smin) v = smin; end
        3: begin v = sx - sy; if (v > smax) v = smax; if (v < smin) v = smin; end
        4: begin v = x + y; if (v > mask) v = mask; end
        5: v = (x > y) ? x - y : 0;
        6: v = (sx > sy) ? mask : 0;
        default: v = (x == y) ? mask : 0;
      endcase
      r = r | (128'(v & mask) << (i * w));
    end
    return r;
  endfunction

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive on negedge; register captures at posedge (R10 one-cycle latency); sample after it
  task automatic run_op(int op, logic [4:0] dst, logic [127:0] a, logic [127:0] b);
    logic [127:0] er;
    logic         ew;
    @(negedge clk_i);
    op_i = 5'(op); dst_i = dst; src_a_i = a; src_b_i = b;
    er = ref_res(op, a, b);
    ew = (op < 28) && (dst != 0);
    @(posedge clk_i);
    #1;
    chk(tag_of(op), $sformatf("res op=%0d", op), res_o, er);
    chk((op >= 28) ? "R9" : "R8", $sformatf("we op=%0d dst=%0d", op, dst), 128'(we_o), 128'(ew));
  endtask

  function automatic logic [31:0] pick32();
    case ($urandom % 8)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7F7F_7FFF;
      4: return 32'h8080_8000;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [127:0] rnd_op();
    logic [127:0] v;
    for (int i = 0; i < 4; i++) v[i*32 +: 32] = pick32();
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    // R10: reset state
    chk("R10", "reset res", res_o, '0);
    chk("R10", "reset we", 128'(we_o), 128'(0));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R3 signed byte clamps
    run_op(6, 5'd1, {16{8'h7F}}, {16{8'h01}});
    run_op(9, 5'd1, {16{8'h80}}, {16{8'h01}});
    run_op(8, 5'd2, {4{32'h8000_0000}}, {4{32'hFFFF_FFFF}});
    // R4 unsigned clamps
    run_op(12, 5'd3, {16{8'hFF}}, {16{8'h01}});
    run_op(15, 5'd3, '0, {16{8'h01}});
    run_op(16, 5'd3, {8{16'h0005}}, {8{16'h0006}});
    // R2 carries must stay inside each lane
    run_op(0, 5'd4, '1, {16{8'h01}});
    run_op(1, 5'd4, {8{16'hFFFF}}, {8{16'h0001}});
    run_op(5, 5'd4, '0, {4{32'h1}});
    // R5 ties and sign
    run_op(18, 5'd5, {16{8'h40}}, {16{8'h40}});
    run_op(20, 5'd5, {4{32'hFFFF_FFFF}}, '0);
    run_op(19, 5'd5, {8{16'h0001}}, {8{16'h8000}});
    // R6 equality mask
    run_op(22, 5'd6, {8{16'h1234}}, {4{32'h1234_1235}});
    // R7 logic full width
    run_op(27, 5'd7, 128'h0F0F, 128'hF000);
    run_op(26, 5'd7, '1, 128'h1);
    // R8 destination zero
    run_op(2, 5'd0, {4{32'h1}}, {4{32'h2}});
    // R9 unsupported codes
    for (int c = 28; c < 32; c++) run_op(c, 5'd9, '1, '1);

    // R1 every opcode, random operands with extreme lanes
    for (int n = 0; n < 600; n++) begin
      int op = $urandom % 32;
      logic [4:0] d = (($urandom % 8) == 0) ? 5'd0 : 5'($urandom);
      run_op(op, d, rnd_op(), rnd_op());
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule